// File: doc/BRIEF.md
# Dual-Mode Host Bus Front End

This block sits between a host microprocessor and a display controller's internal command decoder and display-RAM port. Two static inputs pick the physical path. `par_mode` selects either an 8-bit parallel bus or a write-only serial link. In parallel mode, `bus_style` selects between two bus styles. One uses separate active-low read and write strobes. The other uses an enable strobe together with a read/write level.

Every host strobe, select and data line is asynchronous to `clk` and first passes through a synchronizer chain. Edges are detected on the synchronized copies. Each accepted write byte leaves the block on a valid/ready stream, tagged by the register-select line as either command or display data. The stream holds its beat until the consumer takes it. While a beat is still held, a new byte cannot displace it: the newer byte is dropped. The host protocol cannot be stalled, so the consumer is expected to keep `out_ready` high except for short gaps between host transfers.

A read raises a one-cycle `rd_req` pulse to the downstream port. The block then returns `rd_data` on `bus_out` and raises `bus_oe` for as long as the host read phase lasts. The tri-state pad is not part of this block.

Top module: `host_bus_frontend`

## Requirements
- R1: Every write byte carries the register-select level sampled with it: `reg_sel` low gives `out_cmd` = 0 (display data), high gives `out_cmd` = 1 (command).
- R2: With `par_mode`=1 and `bus_style`=0, a write is the rising edge of the active-low write strobe `strb_b` while `cs_n` is low. The byte on `bus_in` at that edge appears on `out_data`.
- R3: With `par_mode`=1 and `bus_style`=1, a write is the falling edge of the enable `strb_a` while the read/write level `strb_b` is low (low = write) and `cs_n` is low. The byte on `bus_in` is captured at that edge.
- R4: With `par_mode`=0, each rising edge of `ser_clk` while `cs_n` is low shifts in `ser_dat`, most significant bit first. The 8th rising edge completes a byte, and `reg_sel` is sampled at that edge.
- R5: Raising `cs_n` in serial mode clears the bit count, so a partial byte is discarded and the next byte starts fresh.
- R6: While `cs_n` is high, no strobe produces a write beat or a read request.
- R7: With the strobe style selected, `bus_oe` is high while `cs_n` and the read strobe `strb_a` are both low, and `bus_out` follows `rd_data`. The falling edge of the read strobe gives exactly one `rd_req` pulse, with `rd_cmd` equal to `reg_sel`.
- R8: With the enable style selected, `bus_oe` is high while the enable `strb_a` is high, `strb_b` is high (high = read) and `cs_n` is low. The rising edge of the enable gives one `rd_req` pulse.
- R9: In serial mode, `bus_oe` and `rd_req` stay low whatever the strobes do.
- R10: Once `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_cmd` hold until a cycle with `out_ready` high. A byte that arrives while the beat is held and not taken is dropped.
- R11: During reset and in the first cycle after it, `out_valid`, `bus_oe` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_mode | input | 1 | Static path select: 1 parallel, 0 serial |
| bus_style | input | 1 | Static style: 1 enable + read/write level, 0 separate strobes |
| cs_n | input | 1 | Active-low chip select |
| reg_sel | input | 1 | 1 command, 0 display data |
| strb_a | input | 1 | Read strobe (active low) or enable (active high) |
| strb_b | input | 1 | Write strobe (active low) or read/write level (1 read) |
| bus_in | input | 8 | Parallel data from the host |
| ser_clk | input | 1 | Serial clock, shifts on its rising edge |
| ser_dat | input | 1 | Serial data bit |
| out_valid | output | 1 | Write beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 8 | Written byte |
| out_cmd | output | 1 | Tag of the written byte |
| rd_req | output | 1 | One-cycle read request to the downstream port |
| rd_cmd | output | 1 | Tag of the read request |
| rd_data | input | 8 | Read data from the downstream port |
| bus_out | output | 8 | Read data toward the pad |
| bus_oe | output | 1 | Pad output enable |

## Verification
The assertions assume that `par_mode` and `bus_style` change only while the bus is idle. They also assume that each host phase, and the data around each strobe edge, is held for longer than the synchronizer depth, so that one edge is seen once. The stimulus applies every strobe level for at least three clock cycles. It sets data, select and read/write level before the strobe edge and holds them past it, and it changes the mode inputs only with `cs_n` high and all strobes idle.

// File: rtl/hbf_pkg.sv
package hbf_pkg;
  parameter int HBF_DW = 8;
  localparam int HBF_CW = $clog2(HBF_DW);

  typedef struct packed {
    logic              cmd;
    logic [HBF_DW-1:0] data;
  } hbf_xfer_t;
endpackage

// File: rtl/hbf_sync.sv
module hbf_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hbf_par_port.sv
module hbf_par_port
  import hbf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              style,
  input  logic              cs_n_s,
  input  logic              a_s,
  input  logic              b_s,
  input  logic              rs_s,
  input  logic [HBF_DW-1:0] d_s,
  output logic              wr_ev,
  output hbf_xfer_t         wr_x,
  output logic              rd_ev,
  output logic              rd_cmd,
  output logic              oe
);
  logic a_q, b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= 1'b1;
      b_q <= 1'b1;
    end else begin
      a_q <= a_s;
      b_q <= b_s;
    end
  end

  logic a_rise, a_fall, b_rise, sel;
  assign a_rise = a_s & ~a_q;
  assign a_fall = ~a_s & a_q;
  assign b_rise = b_s & ~b_q;
  assign sel    = en & ~cs_n_s;

  always_comb begin
    if (style) begin
      wr_ev = sel & a_fall & ~b_s;
      rd_ev = sel & a_rise & b_s;
      oe    = sel & a_s & b_s;
    end else begin
      wr_ev = sel & b_rise;
      rd_ev = sel & a_fall;
      oe    = sel & ~a_s;
    end
  end

  assign wr_x.cmd  = rs_s;
  assign wr_x.data = d_s;
  assign rd_cmd    = rs_s;
endmodule

// File: rtl/hbf_ser_port.sv
module hbf_ser_port
  import hbf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      cs_n_s,
  input  logic      sclk_s,
  input  logic      sdat_s,
  input  logic      rs_s,
  output logic      wr_ev,
  output hbf_xfer_t wr_x
);
  localparam logic [HBF_CW-1:0] LAST = HBF_CW'(HBF_DW - 1);

  logic              sclk_q;
  logic [HBF_CW-1:0] cnt;
  logic [HBF_DW-1:0] shreg;
  logic              shift;

  assign shift = en & ~cs_n_s & sclk_s & ~sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else begin
      sclk_q <= sclk_s;
      if (cs_n_s || !en) begin
        cnt <= '0;
      end else if (shift) begin
        shreg <= {shreg[HBF_DW-2:0], sdat_s};
        cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  end

  assign wr_ev     = shift & (cnt == LAST);
  assign wr_x.data = {shreg[HBF_DW-2:0], sdat_s};
  assign wr_x.cmd  = rs_s;
endmodule

// File: rtl/hbf_out_stage.sv
module hbf_out_stage
  import hbf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_ev,
  input  hbf_xfer_t in_x,
  input  logic      ready,
  output logic      valid,
  output hbf_xfer_t held
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      held  <= '0;
    end else if (in_ev && (!valid || ready)) begin
      valid <= 1'b1;
      held  <= in_x;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/host_bus_frontend.sv
module host_bus_frontend
  import hbf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_mode,
  input  logic              bus_style,
  input  logic              cs_n,
  input  logic              reg_sel,
  input  logic              strb_a,
  input  logic              strb_b,
  input  logic [HBF_DW-1:0] bus_in,
  input  logic              ser_clk,
  input  logic              ser_dat,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HBF_DW-1:0] out_data,
  output logic              out_cmd,
  output logic              rd_req,
  output logic              rd_cmd,
  input  logic [HBF_DW-1:0] rd_data,
  output logic [HBF_DW-1:0] bus_out,
  output logic              bus_oe
);
  localparam int CTL_W = 4;
  localparam int DAT_W = HBF_DW + 2;

  logic cs_n_s, a_s, b_s, sclk_s, rs_s, sdat_s;
  logic [HBF_DW-1:0] d_s;

  hbf_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, strb_a, strb_b, ser_clk}),
    .q({cs_n_s, a_s, b_s, sclk_s})
  );

  hbf_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n),
    .d({reg_sel, ser_dat, bus_in}),
    .q({rs_s, sdat_s, d_s})
  );

  logic      p_wr, p_rd, p_rcmd, p_oe, s_wr;
  hbf_xfer_t p_x, s_x, sel_x, held_x;

  hbf_par_port u_par (
    .clk(clk), .rst_n(rst_n), .en(par_mode), .style(bus_style),
    .cs_n_s(cs_n_s), .a_s(a_s), .b_s(b_s), .rs_s(rs_s), .d_s(d_s),
    .wr_ev(p_wr), .wr_x(p_x), .rd_ev(p_rd), .rd_cmd(p_rcmd), .oe(p_oe)
  );

  hbf_ser_port u_ser (
    .clk(clk), .rst_n(rst_n), .en(~par_mode), .cs_n_s(cs_n_s),
    .sclk_s(sclk_s), .sdat_s(sdat_s), .rs_s(rs_s),
    .wr_ev(s_wr), .wr_x(s_x)
  );

  assign sel_x = par_mode ? p_x : s_x;

  hbf_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .in_ev(par_mode ? p_wr : s_wr),
    .in_x(sel_x), .ready(out_ready), .valid(out_valid), .held(held_x)
  );

  assign out_data = held_x.data;
  assign out_cmd  = held_x.cmd;

  logic oe_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_req  <= 1'b0;
      rd_cmd  <= 1'b0;
      oe_q    <= 1'b0;
      bus_out <= '0;
    end else begin
      rd_req  <= p_rd;
      rd_cmd  <= p_rd ? p_rcmd : rd_cmd;
      oe_q    <= p_oe;
      bus_out <= rd_data;
    end
  end

  assign bus_oe = oe_q & par_mode;
endmodule

// File: rtl/hbf_checker.sv
module hbf_checker
  import hbf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              par_mode,
  input logic              out_valid,
  input logic              out_ready,
  input logic [HBF_DW-1:0] out_data,
  input logic              out_cmd,
  input logic              rd_req,
  input logic              bus_oe
);
  assert_hold_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_cmd));

  assert_serial_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !par_mode |-> !bus_oe && !rd_req);

  assert_single_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_reset_idle_R11: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !rd_req && !bus_oe);
endmodule

bind host_bus_frontend hbf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_cmd(out_cmd),
  .rd_req(rd_req), .bus_oe(bus_oe)
);

// File: tb/host_bus_frontend_test.sv
`timescale 1ns/1ps
module host_bus_frontend_test;
  logic clk = 0, rst_n = 0;
  logic par_mode = 1, bus_style = 0, cs_n = 1, reg_sel = 0;
  logic strb_a = 1, strb_b = 1, ser_clk = 0, ser_dat = 0, out_ready = 1;
  logic [7:0] bus_in = 0, rd_data = 0;
  logic out_valid, out_cmd, rd_req, rd_cmd, bus_oe;
  logic [7:0] out_data, bus_out;

  int n_chk = 0, n_bad = 0, rx_cnt = 0, rq_cnt = 0, cyc = 0;
  logic [7:0] rx_data;
  logic rx_cmd;

  always #2 clk = ~clk;

  host_bus_frontend uut (.*);

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      rx_cnt++; rx_data = out_data; rx_cmd = out_cmd;
    end
    if (rst_n && rd_req) rq_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc_w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_strobe(input logic [7:0] v, input logic rs, input logic csn);
    cs_n = csn; reg_sel = rs; bus_in = v; cyc_w(3);
    strb_b = 0; cyc_w(3); strb_b = 1; cyc_w(3); cs_n = 1; cyc_w(3);
  endtask

  task automatic wr_enable(input logic [7:0] v, input logic rs);
    cs_n = 0; reg_sel = rs; bus_in = v; strb_b = 0; cyc_w(3);
    strb_a = 1; cyc_w(3); strb_a = 0; cyc_w(3); strb_b = 1; cs_n = 1; cyc_w(3);
  endtask

  task automatic ser_bits(input logic [7:0] v, input int nb, input logic rs);
    cs_n = 0; reg_sel = rs; cyc_w(3);
    for (int i = 7; i > 7 - nb; i--) begin
      ser_dat = v[i]; cyc_w(3); ser_clk = 1; cyc_w(3); ser_clk = 0; cyc_w(3);
    end
    cyc_w(3); cs_n = 1; cyc_w(3);
  endtask

  task automatic chk_rx(input int exp_cnt, input logic [7:0] v, input logic rs, input string req);
    chk(rx_cnt == exp_cnt && rx_data == v && rx_cmd == rs, req,
        {rx_cnt[15:0], 7'd0, rx_cmd, rx_data}, {exp_cnt[15:0], 7'd0, rs, v});
  endtask

  initial begin
    int base;
    cyc_w(4);
    // R11: idle outputs during reset and right after it
    chk(!out_valid && !bus_oe && !rd_req, "R11 reset", {out_valid, bus_oe, rd_req}, 0);
    rst_n = 1; @(posedge clk); #1;
    chk(!out_valid && !bus_oe && !rd_req, "R11 post", {out_valid, bus_oe, rd_req}, 0);
    cyc_w(4);

    // R2 R1: strobe-style writes, every byte value
    for (int v = 0; v < 256; v++) begin
      base = rx_cnt;
      wr_strobe(8'(v), v[0] ^ v[3], 1'b0);
      chk_rx(base + 1, 8'(v), v[0] ^ v[3], "R2 R1 strobe write");
    end
    // R6: chip select high blocks writes and reads
    base = rx_cnt;
    wr_strobe(8'h3C, 1'b1, 1'b1);
    chk(rx_cnt == base, "R6 write ignored", rx_cnt, base);
    strb_a = 0; cyc_w(6);
    chk(!bus_oe && rq_cnt == 0, "R6 read ignored", {bus_oe, rq_cnt[7:0]}, 0);
    strb_a = 1; cyc_w(4);

    // R7: strobe-style reads
    for (int k = 0; k < 4; k++) begin
      base = rq_cnt;
      rd_data = 8'(8'h5A + 37 * k); reg_sel = k[0]; cs_n = 0; cyc_w(2);
      strb_a = 0; cyc_w(6);
      chk(bus_oe && bus_out == rd_data && rq_cnt == base + 1 && rd_cmd == k[0],
          "R7 strobe read", {bus_oe, rd_cmd, bus_out}, {2'b11, k[0], rd_data} & 10'h2FF);
      strb_a = 1; cyc_w(5);
      chk(!bus_oe && rq_cnt == base + 1, "R7 read end", {bus_oe, rq_cnt[7:0]}, base + 1);
      cs_n = 1; cyc_w(3);
    end

    // R10: back-pressure, second byte dropped
    out_ready = 0;
    base = rx_cnt;
    wr_strobe(8'hA1, 1'b0, 1'b0);
    wr_strobe(8'hB2, 1'b1, 1'b0);
    chk(out_valid && out_data == 8'hA1 && !out_cmd, "R10 held", {out_valid, out_cmd, out_data}, 10'h2A1);
    out_ready = 1; cyc_w(4);
    chk_rx(base + 1, 8'hA1, 1'b0, "R10 drop");

    // R3 R1: enable-style writes
    bus_style = 1; strb_a = 0; strb_b = 1; cyc_w(6);
    for (int v = 0; v < 256; v++) begin
      base = rx_cnt;
      wr_enable(8'(v), v[1]);
      chk_rx(base + 1, 8'(v), v[1], "R3 R1 enable write");
    end
    // R8: enable-style reads
    for (int k = 0; k < 3; k++) begin
      base = rq_cnt;
      rd_data = 8'(8'hC3 ^ (k * 17)); cs_n = 0; strb_b = 1; cyc_w(2);
      strb_a = 1; cyc_w(6);
      chk(bus_oe && bus_out == rd_data && rq_cnt == base + 1, "R8 enable read",
          {bus_oe, bus_out}, {1'b1, rd_data});
      strb_a = 0; cyc_w(5);
      chk(!bus_oe && rq_cnt == base + 1, "R8 read end", {bus_oe, rq_cnt[7:0]}, base + 1);
      cs_n = 1; cyc_w(3);
    end

    // R4 R1: serial bytes, every value
    par_mode = 0; bus_style = 0; strb_a = 1; strb_b = 1; cyc_w(6);
    for (int v = 0; v < 256; v++) begin
      base = rx_cnt;
      ser_bits(8'(v), 8, v[2]);
      chk_rx(base + 1, 8'(v), v[2], "R4 R1 serial write");
    end
    // R5: partial byte discarded
    base = rx_cnt;
    ser_bits(8'hFF, 5, 1'b0);
    chk(rx_cnt == base, "R5 partial", rx_cnt, base);
    ser_bits(8'h96, 8, 1'b1);
    chk_rx(base + 1, 8'h96, 1'b1, "R5 fresh byte");
    // R9: serial mode, read strobe does nothing
    base = rq_cnt;
    cs_n = 0; strb_a = 0; cyc_w(6);
    chk(!bus_oe && rq_cnt == base, "R9 serial read", {bus_oe, rq_cnt[7:0]}, base);
    strb_a = 1; cs_n = 1; cyc_w(4);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule